// File: doc/BRIEF.md
# Rotating Window Register File

This block is a general-purpose register file of 32-bit registers. Code sees it through a window of 16 logical registers laid over a larger physical array of 32 or 64 registers, chosen at elaboration. Each logical register number (4 bits) is translated to a physical index by adding a movable window base. The base always sits on a four-register boundary, and the sum wraps around the physical array. A rotate command moves the base forward or backward by 4, 8 or 12 registers. A called routine can then work in fresh registers, and nothing has to be copied out to memory.

The block keeps a mask with one valid bit per group of four registers (a quad). Each bit records whether that quad still belongs to a live window. A forward rotation that would claim a quad which is still live is refused: the base stays where it is and an overflow flag is raised for one cycle. Surrounding control logic is expected to spill and retry. A backward rotation gives the top quads of the departing window back to the free pool.

The block has two combinational read ports and one write port. The write takes effect at the clock edge.

Top module: `wreg_window_file`

## Requirements
- R1: The physical index of logical register L is (4*B + L) modulo PHYS_REGS, where B is the base counted in quads. After reset B is 0, so logical L maps to physical L, and the sum wraps past the top of the array.
- R2: Both read ports are combinational. Each returns the addressed register in the same cycle that its logical index is applied.
- R3: A write with wr_en high is stored at the clock edge and can be read from the next cycle on. A read of the same register in the write's own cycle returns the old contents, because there is no bypass.
- R4: rot_step encodes the move in quads (1 = 4 registers, 2 = 8, 3 = 12); 0 means no move. rot_dir 0 moves forward (B + step) and rot_dir 1 moves backward (B - step), both modulo PHYS_REGS/4. Without rot_en, B is unchanged.
- R5: A write issued in the same cycle as a rotate is translated with the base from before that cycle.
- R6: Synchronous active-high reset sets B to 0, marks only quads 0 to 3 as live, and clears ovf. Register contents are not cleared.
- R7: A forward rotate by s quads is refused if any of the quads B+4 to B+3+s (mod quad count) is live. When that happens, B is unchanged and ovf is high in exactly the following cycle. An accepted forward rotate marks those quads live.
- R8: A backward rotate by s quads marks the top s quads of the old window (B+4-s to B+3) as free and keeps the new window live. A later forward rotate into the freed quads is accepted.
- R9: ovf is low in every cycle that does not directly follow a refused forward rotate.
- R10: The quads of the current window are always marked live.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | 32 | Read data, port A (combinational) |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | 32 | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Logical index for the write |
| wr_data | input | 32 | Write data |
| rot_en | input | 1 | Rotate request |
| rot_dir | input | 1 | 0 forward, 1 backward |
| rot_step | input | 2 | Rotation amount in quads (0 to 3) |
| ovf | output | 1 | One-cycle flag after a refused forward rotate |

## Verification
The checker watches the window controller on every cycle:
- base movement for forward, backward and idle commands;
- base held whenever ovf is raised;
- ovf appearing only after a forward request;
- the current window always marked live;
- the post-reset state.

Some behaviours are visible only in the bench's scenarios, where reads are compared against a reference model of the physical array:
- that data really lands at the translated physical index;
- that wrap-around addresses the right storage;
- that a write concurrent with a rotate goes through the old base;
- that no same-cycle bypass exists;
- that freed quads can be claimed again.

// File: rtl/wwin_pkg.sv
package wwin_pkg;

    localparam int unsigned QUAD_REGS   = 4;
    localparam int unsigned WIN_QUADS   = 4;
    localparam int unsigned LOG_REGS    = QUAD_REGS * WIN_QUADS;
    localparam int unsigned LOG_W       = $clog2(LOG_REGS);
    localparam int unsigned STEP_W      = 2;
    localparam int unsigned NUM_XLATE   = 3;   // read A, read B, write

    typedef enum logic {
        ROT_FWD  = 1'b0,
        ROT_BACK = 1'b1
    } rot_dir_e;

    typedef struct packed {
        logic               en;
        rot_dir_e           dir;
        logic [STEP_W-1:0]  step;
    } rot_cmd_t;

    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_ADV    = 2'd1,
        ACT_RETIRE = 2'd2,
        ACT_REFUSE = 2'd3
    } win_act_e;

endpackage

// File: rtl/wwin_xlate.sv
module wwin_xlate
    import wwin_pkg::*;
#(
    parameter int unsigned PHYS_REGS = 32,
    localparam int unsigned PHYS_W   = $clog2(PHYS_REGS),
    localparam int unsigned BASE_W   = PHYS_W - 2
) (
    input  logic [BASE_W-1:0] base_q,
    input  logic [LOG_W-1:0]  lidx,
    output logic [PHYS_W-1:0] pidx
);
    // Base in quads scaled to registers; natural wrap from PHYS_W truncation.
    logic [PHYS_W-1:0] base_regs;
    logic [PHYS_W-1:0] lidx_ext;

    always_comb begin
        base_regs = {base_q, 2'b00};
        lidx_ext  = PHYS_W'(lidx);
        pidx      = base_regs + lidx_ext;
    end

endmodule

// File: rtl/wwin_storage.sv
module wwin_storage #(
    parameter int unsigned PHYS_REGS = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_RD    = 2,
    localparam int unsigned PHYS_W   = $clog2(PHYS_REGS)
) (
    input  logic                           clk,
    input  logic                           wr_en,
    input  logic [PHYS_W-1:0]              wr_idx,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [NUM_RD-1:0][PHYS_W-1:0]  rd_idx,
    output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data
);
    logic [DATA_W-1:0] cells [PHYS_REGS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_idx] <= wr_data;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        assign rd_data[p] = cells[rd_idx[p]];
    end

endmodule

// File: rtl/wwin_window_ctl.sv
module wwin_window_ctl
    import wwin_pkg::*;
#(
    parameter int unsigned PHYS_REGS = 32,
    localparam int unsigned NQUAD    = PHYS_REGS / QUAD_REGS,
    localparam int unsigned BASE_W   = $clog2(NQUAD)
) (
    input  logic              clk,
    input  logic              rst,
    input  rot_cmd_t          cmd,
    output logic [BASE_W-1:0] base_q,
    output logic [NQUAD-1:0]  live_q,
    output logic              ovf_q
);
    logic [BASE_W-1:0] fwd_base;
    logic [BASE_W-1:0] back_base;
    logic [NQUAD-1:0]  claim;
    logic [NQUAD-1:0]  release_m;
    logic [NQUAD-1:0]  back_win;
    logic [NQUAD-1:0]  reset_win;
    logic              collide;
    win_act_e          act;
    logic [BASE_W-1:0] base_d;
    logic [NQUAD-1:0]  live_d;

    always_comb begin
        fwd_base  = base_q + BASE_W'(cmd.step);
        back_base = base_q - BASE_W'(cmd.step);
        claim     = '0;
        release_m = '0;
        back_win  = '0;
        reset_win = '0;
        for (int k = 0; k < 3; k++) begin
            if (k < int'(cmd.step)) begin
                // quads just above the current window
                claim[BASE_W'(base_q + BASE_W'(WIN_QUADS + k))] = 1'b1;
                // top quads of the current window, handed back
                release_m[BASE_W'(base_q + BASE_W'(WIN_QUADS - 1 - k))] = 1'b1;
            end
        end
        for (int k = 0; k < int'(WIN_QUADS); k++) begin
            back_win[BASE_W'(back_base + BASE_W'(k))] = 1'b1;
            reset_win[k] = 1'b1;
        end
        collide = |(claim & live_q);
    end

    always_comb begin
        act = ACT_IDLE;
        if (cmd.en && (cmd.step != '0)) begin
            if (cmd.dir == ROT_BACK) begin
                act = ACT_RETIRE;
            end else if (collide) begin
                act = ACT_REFUSE;
            end else begin
                act = ACT_ADV;
            end
        end
    end

    always_comb begin
        base_d = base_q;
        live_d = live_q;
        unique case (act)
            ACT_ADV: begin
                base_d = fwd_base;
                live_d = live_q | claim;
            end
            ACT_RETIRE: begin
                base_d = back_base;
                live_d = (live_q & ~release_m) | back_win;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            live_q <= reset_win;
            ovf_q  <= 1'b0;
        end else begin
            base_q <= base_d;
            live_q <= live_d;
            ovf_q  <= (act == ACT_REFUSE);
        end
    end

endmodule

// File: rtl/wreg_window_file.sv
module wreg_window_file
    import wwin_pkg::*;
#(
    parameter int unsigned PHYS_REGS = 32,
    parameter int unsigned DATA_W    = 32,
    localparam int unsigned PHYS_W   = $clog2(PHYS_REGS),
    localparam int unsigned NQUAD    = PHYS_REGS / QUAD_REGS,
    localparam int unsigned BASE_W   = $clog2(NQUAD)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rot_en,
    input  logic              rot_dir,
    input  logic [1:0]        rot_step,
    output logic              ovf
);
    rot_cmd_t                          cmd;
    logic [BASE_W-1:0]                 base_q;
    logic [NQUAD-1:0]                  live_q;
    logic [NUM_XLATE-1:0][LOG_W-1:0]   lidx;
    logic [NUM_XLATE-1:0][PHYS_W-1:0]  pidx;
    logic [1:0][DATA_W-1:0]            rd_data;

    always_comb begin
        cmd.en   = rot_en;
        cmd.dir  = rot_dir_e'(rot_dir);
        cmd.step = rot_step;
    end

    assign lidx[0] = rd_a_idx;
    assign lidx[1] = rd_b_idx;
    assign lidx[2] = wr_idx;

    wwin_window_ctl #(.PHYS_REGS(PHYS_REGS)) u_ctl (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .base_q (base_q),
        .live_q (live_q),
        .ovf_q  (ovf)
    );

    for (genvar g = 0; g < NUM_XLATE; g++) begin : g_xl
        wwin_xlate #(.PHYS_REGS(PHYS_REGS)) u_xl (
            .base_q (base_q),
            .lidx   (lidx[g]),
            .pidx   (pidx[g])
        );
    end

    wwin_storage #(
        .PHYS_REGS (PHYS_REGS),
        .DATA_W    (DATA_W),
        .NUM_RD    (2)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (pidx[2]),
        .wr_data (wr_data),
        .rd_idx  (pidx[1:0]),
        .rd_data (rd_data)
    );

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];

endmodule

// File: rtl/wwin_checker.sv
module wwin_checker #(
    parameter int unsigned PHYS_REGS = 32,
    localparam int unsigned NQUAD    = PHYS_REGS / 4,
    localparam int unsigned BASE_W   = $clog2(NQUAD)
) (
    input logic              clk,
    input logic              rst,
    input logic              rot_en,
    input logic              rot_dir,
    input logic [1:0]        rot_step,
    input logic [BASE_W-1:0] base_q,
    input logic [NQUAD-1:0]  live_q,
    input logic              ovf
);
    logic [NQUAD-1:0] cur_win;
    logic             fwd_req;
    logic             back_req;

    always_comb begin
        cur_win = '0;
        for (int k = 0; k < 4; k++) begin
            cur_win[BASE_W'(base_q + BASE_W'(k))] = 1'b1;
        end
        fwd_req  = rot_en && !rot_dir && (rot_step != 2'd0);
        back_req = rot_en &&  rot_dir && (rot_step != 2'd0);
    end

    p_reset_window_r6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (base_q == '0) && (live_q == NQUAD'(4'hF)) && !ovf);

    p_fwd_move_r4: assert property (@(posedge clk) disable iff (rst)
        (fwd_req && !$past(rst)) |=>
            (ovf || base_q == BASE_W'($past(base_q) + BASE_W'($past(rot_step)))));

    p_back_move_r4: assert property (@(posedge clk) disable iff (rst)
        (back_req && !$past(rst)) |=>
            (base_q == BASE_W'($past(base_q) - BASE_W'($past(rot_step)))));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!fwd_req && !back_req && !$past(rst)) |=> $stable(base_q));

    p_refuse_holds_r7: assert property (@(posedge clk) disable iff (rst)
        ovf |-> $stable(base_q) && $stable(live_q));

    p_ovf_cause_r9: assert property (@(posedge clk) disable iff (rst)
        ovf |-> $past(fwd_req));

    p_window_live_r10: assert property (@(posedge clk) disable iff (rst)
        (live_q & cur_win) == cur_win);

endmodule

bind wreg_window_file wwin_checker #(.PHYS_REGS(PHYS_REGS)) u_wwin_chk (
    .clk      (clk),
    .rst      (rst),
    .rot_en   (rot_en),
    .rot_dir  (rot_dir),
    .rot_step (rot_step),
    .base_q   (base_q),
    .live_q   (live_q),
    .ovf      (ovf)
);

// File: tb/wreg_window_file_test.sv
module wreg_window_file_test;

    localparam int P  = 32;
    localparam int NQ = P / 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, rot_en = 1'b0, rot_dir = 1'b0;
    logic [1:0]  rot_step = '0;
    logic        ovf;

    always #5 clk = ~clk;

    wreg_window_file #(.PHYS_REGS(P), .DATA_W(32)) uut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rot_en(rot_en), .rot_dir(rot_dir), .rot_step(rot_step),
        .ovf(ovf)
    );

    // reference model
    logic [31:0] m_reg [P];
    bit          m_known [P];
    int          m_base;
    bit [NQ-1:0] m_live;
    bit          m_ovf;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    function automatic int pmap(input int l);
        return (m_base * 4 + l) % P;
    endfunction

    function automatic bit fwd_collides(input int s);
        for (int k = 0; k < s; k++)
            if (m_live[(m_base + 4 + k) % NQ]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_base = 0;
        m_live = '0;
        for (int k = 0; k < 4; k++) m_live[k] = 1'b1;
        m_ovf = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rot_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // One clock: drive, compare reads/ovf before the edge, then advance the model.
    task automatic cyc(input bit we, input int wi, input logic [31:0] wd,
                       input bit re, input bit rdir, input int rs,
                       input int ra, input int rb, input string tag);
        int s;
        @(negedge clk);
        wr_en = we; wr_idx = 4'(wi); wr_data = wd;
        rot_en = re; rot_dir = rdir; rot_step = 2'(rs);
        rd_a_idx = 4'(ra); rd_b_idx = 4'(rb);
        #1;
        if (m_known[pmap(ra)]) check({tag, " port A"}, rd_a_data, m_reg[pmap(ra)]);
        if (m_known[pmap(rb)]) check({tag, " port B"}, rd_b_data, m_reg[pmap(rb)]);
        check(m_ovf ? "R7 ovf" : "R9 ovf", {31'd0, ovf}, {31'd0, m_ovf});
        @(posedge clk);
        if (we) begin
            m_reg[pmap(wi)]   = wd;
            m_known[pmap(wi)] = 1'b1;
        end
        s = re ? rs : 0;
        m_ovf = 1'b0;
        if (s != 0) begin
            if (!rdir) begin
                if (fwd_collides(s)) m_ovf = 1'b1;
                else begin
                    for (int k = 0; k < s; k++) m_live[(m_base + 4 + k) % NQ] = 1'b1;
                    m_base = (m_base + s) % NQ;
                end
            end else begin
                for (int k = 0; k < s; k++) m_live[(m_base + 3 - k) % NQ] = 1'b0;
                m_base = (m_base - s + NQ) % NQ;
                for (int k = 0; k < 4; k++) m_live[(m_base + k) % NQ] = 1'b1;
            end
        end
    endtask

    task automatic idle_read(input int ra, input int rb, input string tag);
        cyc(0, 0, 0, 0, 0, 0, ra, rb, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < P; i++) m_known[i] = 1'b0;
        model_reset();
        do_reset();

        // R6: reset state
        #1;
        check("R6 ovf after reset", {31'd0, ovf}, 32'd0);

        // R1/R2: fill window at base 0, identity mapping
        for (int i = 0; i < 16; i++) cyc(1, i, 32'h100 + i, 0, 0, 0, 0, 0, "R2");
        idle_read(3, 12, "R1 identity");
        check("R1 logical 3 -> physical 3", rd_a_data, 32'h103);
        check("R2 port B logical 12", rd_b_data, 32'h10C);

        // R3: no same-cycle bypass, visible next cycle
        @(negedge clk);
        wr_en = 1; wr_idx = 5; wr_data = 32'hAAAA_0005; rd_a_idx = 5; rot_en = 0;
        #1 check("R3 old value in write cycle", rd_a_data, 32'h105);
        @(posedge clk);
        m_reg[5] = 32'hAAAA_0005;
        @(negedge clk);
        wr_en = 0;
        #1 check("R3 new value next cycle", rd_a_data, 32'hAAAA_0005);

        // R5: write during forward rotate uses old base
        cyc(1, 0, 32'hBEEF_0000, 1, 0, 1, 0, 0, "R5");
        idle_read(0, 12, "R4 fwd by 4");
        check("R4 logical 0 after +4 -> physical 4", rd_a_data, 32'h104);
        cyc(0, 0, 0, 1, 1, 1, 0, 0, "R4");
        idle_read(0, 1, "R5 back");
        check("R5 concurrent write landed at old base", rd_a_data, 32'hBEEF_0000);

        // R7: fill forward until a collision
        cyc(0, 0, 0, 1, 0, 3, 0, 0, "R4 fwd 12");
        cyc(0, 0, 0, 1, 0, 1, 0, 0, "R4 fwd 4");
        cyc(0, 0, 0, 1, 0, 1, 0, 0, "R7 colliding request");
        #1 check("R7 ovf raised after refused rotate", {31'd0, ovf}, 32'd1);
        idle_read(0, 4, "R7 base held");
        #1 check("R9 ovf drops after one cycle", {31'd0, ovf}, 32'd0);

        // R8: retire two quads, reclaim them without overflow
        cyc(0, 0, 0, 1, 1, 2, 0, 0, "R8 retire");
        cyc(0, 0, 0, 1, 0, 2, 0, 0, "R8 reclaim");
        #1 check("R8 no ovf on reclaimed quads", {31'd0, ovf}, 32'd0);
        cyc(0, 0, 0, 1, 0, 1, 0, 0, "R7 second collision");
        #1 check("R7 ovf again", {31'd0, ovf}, 32'd1);

        // R6 + R1 wrap: reset keeps contents; backward from base 0 wraps
        do_reset();
        idle_read(0, 3, "R6 contents kept");
        check("R6 base 0 after reset", rd_a_data, 32'hBEEF_0000);
        cyc(0, 0, 0, 1, 1, 1, 0, 0, "R4 wrap back");
        idle_read(4, 5, "R1 wrap");
        check("R1 logical 4 at top base wraps to physical 0", rd_a_data, 32'hBEEF_0000);
        check("R1 logical 5 wraps to physical 1", rd_b_data, 32'h101);

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            bit we, re, rd;
            int rs;
            we = ($urandom % 2) == 1;
            re = ($urandom % 4) == 0;
            rd = ($urandom % 2) == 1;
            rs = int'($urandom % 4);
            cyc(we, int'($urandom % 16), $urandom, re, rd, rs,
                int'($urandom % 16), int'($urandom % 16), "R1 random");
            if (($urandom % 500) == 0) do_reset();
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule